// File: doc/BRIEF.md
# SIMD Lane Enable and Loop Controller

This block owns the per-lane enable mask of an eight-lane SIMD machine. Every lane operation downstream is gated by its lane's bit in the mask, and the mask is rewritten by a small set of decoded control operations. These operations set the number of active lanes, start and advance a strip-mined loop over an array, and enter, flip and leave conditional regions driven by per-lane compare results.

The loop step moves the element index forward by the active-lane count. Lanes whose element falls past the array length are switched off, so an array of any length can be processed. A count of one gives plain scalar execution. Conditional operations keep the enclosing mask on a LIFO stack. An if, else and endif therefore need no separate save or restore operations, and conditionals nest up to the stack depth. A branch-taken flag tells the sequencer that no lane is left active, so it can skip the region.

Each operation is presented for one cycle on `op_i`. The mask and flags it produces are registered and appear after the next rising clock edge.

Top module: `simd_lane_ctrl`

## Requirements
- R1: After reset, `mask_o` is 8'hFF, the active-lane count is 8, `loop_cont_o`, `branch_taken_o` and `stack_err_o` are 0, and the mask stack is empty.
- R2: Op code 1 (set lanes) sets the active count from `arg_i`: 0 becomes 1, any value above 8 becomes 8. `mask_o` then has the low count bits set.
- R3: Op code 2 (loop start) sets the index to 0 and the length to `arg_i`. Lane i is enabled when i < count and i < length. `loop_cont_o` is 1 when the length is non-zero.
- R4: Op code 3 (loop step) adds the count to the index, but only while the index is below the length; otherwise the index holds. Lane i is enabled when i < count and index+i < length. `loop_cont_o` is 1 when the new index is below the length.
- R5: Op code 4 (if) pushes the current mask and sets the mask to current AND `cmp_i`. `branch_taken_o` is 1 when the result is zero.
- R6: Op code 5 (else) sets the mask to the stack top AND NOT the current mask. The stack is left unchanged. `branch_taken_o` is 1 when the result is zero.
- R7: Op code 6 (endif) restores the mask from the stack top and pops the stack.
- R8: The stack holds 8 masks, so eight nested if operations succeed and eight endif operations unwind them in reverse order.
- R9: An if on a full stack sets `stack_err_o`. It leaves the mask and the stack unchanged and gives `branch_taken_o` = 0.
- R10: An else or endif on an empty stack sets `stack_err_o` and leaves the mask unchanged.
- R11: `loop_cont_o` is set only after a loop start or loop step. `branch_taken_o` is set only after an if or else. Both clear on the next operation of another kind. `stack_err_o` stays set until reset.
- R12: Op codes 0 (no-op) and 7 (reserved) leave the mask, count, loop state and stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Control operation code |
| arg_i | input | 16 | Lane count or array length |
| cmp_i | input | 8 | Per-lane compare results |
| mask_o | output | 8 | Lane enable mask |
| loop_cont_o | output | 1 | Loop has elements left |
| branch_taken_o | output | 1 | No lane active after branch op |
| stack_err_o | output | 1 | Sticky stack overflow/underflow |

## Verification
The bench targets the array tail where the length is not a multiple of the count. A design that gets this wrong either runs lanes past the end or drops the last partial strip. It covers clamping of the lane count at 0 and above 8; a design without this would stall with no lanes or wrap into a wrong mask. It exercises an else after an if whose compare disabled every lane, and a full eight-deep nest. Mixing up the AND NOT operands, or the stack pointer, shows there as a wrong restored mask. It also overflows and underflows the stack to show that the mask survives and the error stays set. A design that corrupts state there loses the enclosing mask.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_SETN  = 3'd1,
    OP_LINIT = 3'd2,
    OP_LSTEP = 3'd3,
    OP_IF    = 3'd4,
    OP_ELSE  = 3'd5,
    OP_ENDIF = 3'd6,
    OP_RSVD  = 3'd7
  } lane_op_e;
endpackage

// File: rtl/lane_count.sv
module lane_count #(
  parameter int unsigned LANES = 8,
  parameter int unsigned IDX_W = 16,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] arg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [LANES-1:0] base_mask_o
);
  logic [CNT_W-1:0] nxt_cnt;

  always_comb begin
    if (arg_i == '0)                    nxt_cnt = CNT_W'(1);
    else if (arg_i > IDX_W'(LANES))     nxt_cnt = CNT_W'(LANES);
    else                                nxt_cnt = arg_i[CNT_W-1:0];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_base
    assign base_mask_o[i] = (CNT_W'(i) < nxt_cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= CNT_W'(LANES);
    else if (set_i) cnt_o <= nxt_cnt;
  end
endmodule

// File: rtl/loop_track.sv
module loop_track #(
  parameter int unsigned LANES = 8,
  parameter int unsigned IDX_W = 16,
  localparam int unsigned CNT_W = $clog2(LANES + 1),
  localparam int unsigned SUM_W = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] arg_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LANES-1:0] mask_o,
  output logic             cont_o
);
  logic [IDX_W:0]   idx_q, idx_d;
  logic [IDX_W-1:0] len_q, len_d;

  always_comb begin
    idx_d = idx_q;
    len_d = len_q;
    if (init_i) begin
      idx_d = '0;
      len_d = arg_i;
    end else if (step_i && (idx_q < {1'b0, len_q})) begin
      // no advance once past the tail, so the index cannot wrap
      idx_d = idx_q + (IDX_W+1)'(cnt_i);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_tail
    assign mask_o[i] = (CNT_W'(i) < cnt_i) &&
                       ((SUM_W'(idx_d) + SUM_W'(i)) < SUM_W'(len_d));
  end

  assign cont_o = idx_d < {1'b0, len_d};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= '0;
    end else begin
      idx_q <= idx_d;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned DEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] din_i,
  output logic [LANES-1:0] top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [DEP_W-1:0] depth_o
);
  logic [LANES-1:0] mem_q [DEPTH];
  logic [DEP_W-1:0] dep_q;
  logic [DEP_W-1:0] top_sel;

  assign empty_o = (dep_q == '0);
  assign full_o  = (dep_q == DEP_W'(DEPTH));
  assign depth_o = dep_q;
  assign top_sel = dep_q - DEP_W'(1);
  assign top_o   = empty_o ? '0 : mem_q[top_sel[PTR_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dep_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[dep_q[PTR_W-1:0]] <= din_i;
      dep_q <= dep_q + DEP_W'(1);
    end else if (pop_i && !empty_o) begin
      dep_q <= dep_q - DEP_W'(1);
    end
  end
endmodule

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] arg_i,
  input  logic [LANES-1:0] cmp_i,
  output logic [LANES-1:0] mask_o,
  output logic             loop_cont_o,
  output logic             branch_taken_o,
  output logic             stack_err_o
);
  import simd_lane_pkg::*;

  localparam int unsigned CNT_W = $clog2(LANES + 1);
  localparam int unsigned DEP_W = $clog2(DEPTH + 1);

  lane_op_e         op;
  logic [CNT_W-1:0] cnt;
  logic [LANES-1:0] base_mask, loop_mask, stk_top;
  logic             loop_cont, stk_empty, stk_full;
  logic [DEP_W-1:0] stk_depth;
  logic             do_push, do_pop;

  logic [LANES-1:0] mask_d;
  logic             cont_d, taken_d, err_d;

  assign op = lane_op_e'(op_i);

  lane_count #(.LANES(LANES), .IDX_W(IDX_W)) u_count (
    .clk_i, .rst_ni,
    .set_i       (op == OP_SETN),
    .arg_i,
    .cnt_o       (cnt),
    .base_mask_o (base_mask)
  );

  loop_track #(.LANES(LANES), .IDX_W(IDX_W)) u_loop (
    .clk_i, .rst_ni,
    .init_i (op == OP_LINIT),
    .step_i (op == OP_LSTEP),
    .arg_i,
    .cnt_i  (cnt),
    .mask_o (loop_mask),
    .cont_o (loop_cont)
  );

  assign do_push = (op == OP_IF) && !stk_full;
  assign do_pop  = (op == OP_ENDIF) && !stk_empty;

  mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk_i, .rst_ni,
    .push_i  (do_push),
    .pop_i   (do_pop),
    .din_i   (mask_o),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full),
    .depth_o (stk_depth)
  );

  always_comb begin
    mask_d  = mask_o;
    cont_d  = 1'b0;
    taken_d = 1'b0;
    err_d   = stack_err_o;
    unique case (op)
      OP_SETN: mask_d = base_mask;
      OP_LINIT, OP_LSTEP: begin
        mask_d = loop_mask;
        cont_d = loop_cont;
      end
      OP_IF: begin
        if (stk_full) err_d = 1'b1;
        else begin
          mask_d  = mask_o & cmp_i;
          taken_d = (mask_d == '0);
        end
      end
      OP_ELSE: begin
        if (stk_empty) err_d = 1'b1;
        else begin
          mask_d  = stk_top & ~mask_o;
          taken_d = (mask_d == '0);
        end
      end
      OP_ENDIF: begin
        if (stk_empty) err_d = 1'b1;
        else           mask_d = stk_top;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o         <= '1;
      loop_cont_o    <= 1'b0;
      branch_taken_o <= 1'b0;
      stack_err_o    <= 1'b0;
    end else begin
      mask_o         <= mask_d;
      loop_cont_o    <= cont_d;
      branch_taken_o <= taken_d;
      stack_err_o    <= err_d;
    end
  end
endmodule

// File: rtl/simd_lane_ctrl_chk.sv
module simd_lane_ctrl_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DEP_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic [LANES-1:0] mask_o,
  input logic             loop_cont_o,
  input logic             branch_taken_o,
  input logic             stack_err_o,
  input logic [DEP_W-1:0] stk_depth
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_taken_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && branch_taken_o) |-> ($past(op_i) == 3'd4 || $past(op_i) == 3'd5));

  p_cont_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && loop_cont_o) |-> ($past(op_i) == 3'd2 || $past(op_i) == 3'd3));

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(stack_err_o)) |-> stack_err_o);

  p_nop_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ($past(op_i) == 3'd0 || $past(op_i) == 3'd7)) |-> $stable(mask_o));

  p_if_shrinks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) == 3'd4) |-> ((mask_o & ~$past(mask_o)) == '0));

  p_taken_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_taken_o |-> (mask_o == '0));

  p_step_tail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) == 3'd3 && !loop_cont_o) |-> (mask_o == '0));

  p_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(op_i) == 3'd4 && $past(stk_depth) == DEP_W'(DEPTH))
      |-> (stack_err_o && $stable(mask_o) && $stable(stk_depth)));

  p_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ($past(op_i) == 3'd5 || $past(op_i) == 3'd6) && $past(stk_depth) == '0)
      |-> (stack_err_o && $stable(mask_o)));

  p_depth_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_depth <= DEP_W'(DEPTH));
endmodule

bind simd_lane_ctrl simd_lane_ctrl_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .op_i           (op_i),
  .mask_o         (mask_o),
  .loop_cont_o    (loop_cont_o),
  .branch_taken_o (branch_taken_o),
  .stack_err_o    (stack_err_o),
  .stk_depth      (stk_depth)
);

// File: tb/tb_simd_lane_ctrl.sv
module tb_simd_lane_ctrl;
  localparam int LANES = 8;
  localparam int DEPTH = 8;
  localparam int IDX_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       op = 3'd0;
  logic [IDX_W-1:0] arg = '0;
  logic [LANES-1:0] cmp = '0;
  logic [LANES-1:0] mask;
  logic             cont, taken, err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  simd_lane_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .IDX_W(IDX_W)) dut (
    .clk_i (clk), .rst_ni (rst_n), .op_i (op), .arg_i (arg), .cmp_i (cmp),
    .mask_o (mask), .loop_cont_o (cont), .branch_taken_o (taken), .stack_err_o (err)
  );

  typedef struct {
    logic [7:0] mask;
    logic       cont;
    logic       taken;
    logic       err;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // bench-side model state
  int         m_cnt, m_idx, m_len;
  logic [7:0] m_mask;
  logic       m_err;
  logic [7:0] m_stk[$];

  function automatic void model_reset();
    m_cnt = 8; m_idx = 0; m_len = 0; m_mask = 8'hFF; m_err = 1'b0;
    m_stk.delete();
  endfunction

  function automatic logic [7:0] tail_mask();
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = (i < m_cnt) && (m_idx + i < m_len);
    return r;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (mask !== e.mask || cont !== e.cont || taken !== e.taken || err !== e.err) begin
      errors++;
      $display("FAIL %s: mask=%h cont=%b taken=%b err=%b expected mask=%h cont=%b taken=%b err=%b",
               e.tag, mask, cont, taken, err, e.mask, e.cont, e.taken, e.err);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; op = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    // R1 reset state
    compare('{8'hFF, 1'b0, 1'b0, 1'b0, "R1 reset"});
  endtask

  task automatic drive(input logic [2:0] o, input int a, input logic [7:0] c, input string tag);
    exp_t e;
    int n;
    @(negedge clk);
    op = o; arg = IDX_W'(a); cmp = c;
    e.cont = 1'b0; e.taken = 1'b0;
    case (o)
      3'd1: begin
        n = (a == 0) ? 1 : (a > 8) ? 8 : a;
        m_cnt = n;
        m_mask = 8'((16'h1 << n) - 1);
      end
      3'd2: begin
        m_idx = 0; m_len = a;
        m_mask = tail_mask(); e.cont = (m_len > 0);
      end
      3'd3: begin
        if (m_idx < m_len) m_idx += m_cnt;
        m_mask = tail_mask(); e.cont = (m_idx < m_len);
      end
      3'd4: begin
        if (m_stk.size() == DEPTH) m_err = 1'b1;
        else begin
          m_stk.push_back(m_mask);
          m_mask = m_mask & c; e.taken = (m_mask == 0);
        end
      end
      3'd5: begin
        if (m_stk.size() == 0) m_err = 1'b1;
        else begin
          m_mask = m_stk[$] & ~m_mask; e.taken = (m_mask == 0);
        end
      end
      3'd6: begin
        if (m_stk.size() == 0) m_err = 1'b1;
        else m_mask = m_stk.pop_back();
      end
      default: ;
    endcase
    e.mask = m_mask; e.err = m_err; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: results appear after the edge following the drive
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) compare(exp_q.pop_front());
  end

  task automatic idle();
    @(negedge clk);
    op = 3'd0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    drive(3'd0, 0, 8'h00, "R12 nop");
    drive(3'd7, 5, 8'h00, "R12 reserved op");
    // full width loop with tail of 4
    drive(3'd2, 20, 8'h00, "R3 loop start len 20");
    drive(3'd3, 0, 8'h00, "R4 step idx 8");
    drive(3'd3, 0, 8'h00, "R4 step idx 16 tail");
    drive(3'd3, 0, 8'h00, "R4 step past end");
    drive(3'd3, 0, 8'h00, "R4 step holds past end");
    // narrow count
    drive(3'd1, 3, 8'h00, "R2 set count 3");
    drive(3'd2, 7, 8'h00, "R3 loop start len 7 count 3");
    drive(3'd3, 0, 8'h00, "R4 step idx 3");
    drive(3'd3, 0, 8'h00, "R4 step idx 6 single lane");
    drive(3'd3, 0, 8'h00, "R4 step idx 9 done");
    drive(3'd1, 0, 8'h00, "R2 count 0 clamps to 1");
    drive(3'd2, 5, 8'h00, "R2 scalar loop start");
    drive(3'd3, 0, 8'h00, "R2 scalar step");
    drive(3'd1, 200, 8'h00, "R2 count 200 clamps to 8");
    drive(3'd2, 0, 8'h00, "R3 zero length");
    drive(3'd2, 100, 8'h00, "R3 loop start len 100");
    // conditionals
    drive(3'd6, 0, 8'h00, "R10 endif on empty");
    drive(3'd0, 0, 8'h00, "R11 err sticky");
    do_reset();
    drive(3'd5, 0, 8'h00, "R10 else on empty");
    do_reset();
    drive(3'd4, 0, 8'hA5, "R5 if");
    drive(3'd4, 0, 8'h0F, "R5 nested if");
    drive(3'd5, 0, 8'h00, "R6 nested else");
    drive(3'd6, 0, 8'h00, "R7 inner endif");
    drive(3'd5, 0, 8'h00, "R6 outer else");
    drive(3'd6, 0, 8'h00, "R7 outer endif");
    drive(3'd4, 0, 8'h00, "R5 if all lanes off taken");
    drive(3'd0, 0, 8'h00, "R11 taken clears");
    drive(3'd5, 0, 8'h00, "R6 else after empty then");
    drive(3'd4, 0, 8'hFF, "R6 if inside else");
    drive(3'd5, 0, 8'h00, "R6 else taken when then is full");
    drive(3'd6, 0, 8'h00, "R7 endif");
    drive(3'd6, 0, 8'h00, "R7 endif to top");
    // eight-deep nest then overflow
    for (int k = 0; k < DEPTH; k++) drive(3'd4, 0, 8'hFF >> k, "R8 deep if");
    drive(3'd4, 0, 8'h00, "R9 if on full stack");
    for (int k = 0; k < DEPTH; k++) drive(3'd6, 0, 8'h00, "R8 unwind");
    drive(3'd2, 9, 8'h00, "R11 cont after if");
    drive(3'd4, 0, 8'h00, "R11 cont clears");
    // mixed traffic
    do_reset();
    for (int k = 0; k < 300; k++)
      drive(3'($urandom_range(0, 7)), $urandom_range(0, 40), 8'($urandom), "R11 mixed");
    idle();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule